// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block brings a DDR2 memory subsystem from cold reset to a usable state with no processor involvement. Once it sees a start pulse it walks a fixed program of eighteen register writes into the memory controller. The program first switches on the PHY clock. It then resets the PHY and launches its calibration. Next come twelve DRAM mode, precharge and refresh commands, each followed by a settling pause. It ends by loading the controller's timing, latency and configuration registers. When the final write has been accepted, a done flag rises and stays high.

The writes leave on a small register bus: a 3-bit register select, a 32-bit data word and a valid/ready handshake. A 32-bit mode word is supplied by the integrator. Its low half becomes the argument of the final MRS command, and its high half is merged into the argument of the last EMRS command. The settling pause is a parameter counted in clock cycles. Its default of 10000 cycles corresponds to the nominal 200 µs at a 50 MHz clock. All DRAM command codes and argument flag values are parameters as well.

Top module: `ddr2_init_seq`

## Requirements
- R1: While reset is high, and after reset until a start pulse is seen, `wr_valid` and `done` are low. A reset in the middle of the sequence returns the block to this idle state.
- R2: `wr_valid` first rises exactly SETTLE_CYCLES+1 cycles after the cycle in which `start` is sampled high. That first write uses select 0 (PHY config) and data with only bit PHY_EN_BIT set.
- R3: After another settling pause, two writes go to select 1 (PHY control). The first carries the PHY-reset bit (bit 0) and the calibration-reset bit (bit 1). The second carries only the calibration-start bit (bit 2) and is presented in the cycle right after the first one's handshake.
- R4: Each DRAM command is one write to select 2, with data = {8'h00, code[7:0], arg[15:0]}. The twelve commands come in this order: deselect/0, precharge/PRE_ALL, EMRS2/0, EMRS3/0, EMRS/DLL_EN, MRS/DLL_RST, precharge/PRE_ALL, refresh/0, refresh/0, MRS/mode, EMRS/OCD_DEFAULT|DLL_EN, EMRS/OCD_EXIT|DLL_EN|mode-high.
- R5: The tenth command's argument is `mode_word[15:0]`. The twelfth command's argument is OCD_EXIT | DLL_EN | `mode_word[31:16]`.
- R6: The first command write and every write that follows a command handshake appear exactly SETTLE_CYCLES+1 cycles after the previous handshake. `wr_valid` stays low in between.
- R7: After the settling pause that follows the last command, `timing_val`, `latency_val` and `config_val` are written, in that order, to selects 3, 4 and 5. Each of these writes is presented in the cycle after the previous handshake.
- R8: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_sel` and `wr_data` hold their values into the next cycle. A write completes in a cycle where both are high.
- R9: `done` rises in the cycle after the select-5 handshake and stays high until reset.
- R10: A `start` pulse that arrives while the sequence runs, or after `done`, changes nothing. The write order and timing stay the same, and no write follows `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins the sequence when idle |
| mode_word | input | 32 | Low half: MRS argument; high half: merged into last EMRS argument |
| timing_val | input | 32 | Value for the timing register |
| latency_val | input | 32 | Value for the latency register |
| config_val | input | 32 | Value for the configuration register |
| wr_ready | input | 1 | Controller accepts the current write |
| wr_sel | output | 3 | Target register select (0 PHY cfg, 1 PHY ctrl, 2 command, 3 timing, 4 latency, 5 config) |
| wr_data | output | 32 | Write data |
| wr_valid | output | 1 | Write request |
| done | output | 1 | Sequence complete (sticky until reset) |

## Verification
The hardest situation to reach is a controller that holds `wr_ready` low across a write while an extra `start` pulse lands during a settling pause. The stall is what tests that the request holds and that no handshake is lost. The extra pulse is what tests that a running sequence cannot restart. One directed run therefore drives `wr_ready` from a repeating stall pattern and fires a second start in the middle of a pause. It then checks every handshake's select, data and exact cycle distance from the previous handshake against the expected program. Another run asserts reset partway through the command list to show the block falls back to idle.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

    localparam int IDX_W = 5;
    localparam logic [IDX_W-1:0] STEP_PHY_CFG   = 5'd0;
    localparam logic [IDX_W-1:0] STEP_PHY_RST   = 5'd1;
    localparam logic [IDX_W-1:0] STEP_FIRST_CMD = 5'd3;
    localparam logic [IDX_W-1:0] STEP_TIMING    = 5'd15;
    localparam logic [IDX_W-1:0] STEP_LAST      = 5'd17;

    typedef enum logic [2:0] {
        SEL_PHY_CFG  = 3'd0,
        SEL_PHY_CTRL = 3'd1,
        SEL_CMD      = 3'd2,
        SEL_TIMING   = 3'd3,
        SEL_LATENCY  = 3'd4,
        SEL_CONFIG   = 3'd5
    } wsel_e;

    typedef struct packed {
        wsel_e       sel;
        logic [31:0] data;
    } wr_step_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_WRITE,
        ST_DONE
    } seq_state_e;

    // Command register word: code in [23:16], argument in [15:0].
    function automatic logic [31:0] pack_cmd(input logic [7:0] code, input logic [15:0] arg);
        return {8'h00, code, arg};
    endfunction

    // A settling pause precedes the PHY enable, the PHY reset, every
    // command, and the timing write that follows the last command.
    function automatic logic settle_before(input logic [IDX_W-1:0] i);
        return (i == STEP_PHY_CFG) || (i == STEP_PHY_RST) ||
               ((i >= STEP_FIRST_CMD) && (i <= STEP_TIMING));
    endfunction

endpackage

// File: rtl/settle_timer.sv
module settle_timer #(
    parameter int SETTLE_CYCLES = 10000
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);
    localparam int CW = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CW-1:0] RELOAD = CW'(SETTLE_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= RELOAD;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/init_step_rom.sv
module init_step_rom
    import ddr2_init_pkg::*;
#(
    parameter int          PHY_EN_BIT    = 0,
    parameter int          PHY_RST_BIT   = 0,
    parameter int          CAL_RST_BIT   = 1,
    parameter int          CAL_START_BIT = 2,
    parameter logic [7:0]  CODE_DESELECT = 8'h0F,
    parameter logic [7:0]  CODE_PRE      = 8'h02,
    parameter logic [7:0]  CODE_REFRESH  = 8'h01,
    parameter logic [7:0]  CODE_MRS      = 8'h10,
    parameter logic [7:0]  CODE_EMRS     = 8'h11,
    parameter logic [7:0]  CODE_EMRS2    = 8'h12,
    parameter logic [7:0]  CODE_EMRS3    = 8'h13,
    parameter logic [15:0] ARG_PRE_ALL   = 16'h0400,
    parameter logic [15:0] ARG_DLL_EN    = 16'h0002,
    parameter logic [15:0] ARG_DLL_RST   = 16'h0100,
    parameter logic [15:0] ARG_OCD_DFLT  = 16'h0380,
    parameter logic [15:0] ARG_OCD_EXIT  = 16'h0000
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [31:0]      mode_word,
    input  logic [31:0]      timing_val,
    input  logic [31:0]      latency_val,
    input  logic [31:0]      config_val,
    output wr_step_t         step
);
    localparam logic [31:0] PHY_CFG_WORD   = 32'(1) << PHY_EN_BIT;
    localparam logic [31:0] PHY_RESET_WORD = (32'(1) << PHY_RST_BIT) | (32'(1) << CAL_RST_BIT);
    localparam logic [31:0] PHY_CAL_WORD   = 32'(1) << CAL_START_BIT;

    always_comb begin
        step.sel  = SEL_CMD;
        step.data = '0;
        case (idx)
            5'd0:  begin step.sel = SEL_PHY_CFG;  step.data = PHY_CFG_WORD;   end
            5'd1:  begin step.sel = SEL_PHY_CTRL; step.data = PHY_RESET_WORD; end
            5'd2:  begin step.sel = SEL_PHY_CTRL; step.data = PHY_CAL_WORD;   end
            5'd3:  step.data = pack_cmd(CODE_DESELECT, 16'h0000);
            5'd4:  step.data = pack_cmd(CODE_PRE, ARG_PRE_ALL);
            5'd5:  step.data = pack_cmd(CODE_EMRS2, 16'h0000);
            5'd6:  step.data = pack_cmd(CODE_EMRS3, 16'h0000);
            5'd7:  step.data = pack_cmd(CODE_EMRS, ARG_DLL_EN);
            5'd8:  step.data = pack_cmd(CODE_MRS, ARG_DLL_RST);
            5'd9:  step.data = pack_cmd(CODE_PRE, ARG_PRE_ALL);
            5'd10: step.data = pack_cmd(CODE_REFRESH, 16'h0000);
            5'd11: step.data = pack_cmd(CODE_REFRESH, 16'h0000);
            5'd12: step.data = pack_cmd(CODE_MRS, mode_word[15:0]);
            5'd13: step.data = pack_cmd(CODE_EMRS, ARG_OCD_DFLT | ARG_DLL_EN);
            5'd14: step.data = pack_cmd(CODE_EMRS, ARG_OCD_EXIT | ARG_DLL_EN | mode_word[31:16]);
            5'd15: begin step.sel = SEL_TIMING;  step.data = timing_val;  end
            5'd16: begin step.sel = SEL_LATENCY; step.data = latency_val; end
            5'd17: begin step.sel = SEL_CONFIG;  step.data = config_val;  end
            default: begin step.sel = SEL_CMD; step.data = '0; end
        endcase
    end
endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
    import ddr2_init_pkg::*;
#(
    parameter int          SETTLE_CYCLES = 10000,
    parameter int          PHY_EN_BIT    = 0,
    parameter int          PHY_RST_BIT   = 0,
    parameter int          CAL_RST_BIT   = 1,
    parameter int          CAL_START_BIT = 2,
    parameter logic [7:0]  CODE_DESELECT = 8'h0F,
    parameter logic [7:0]  CODE_PRE      = 8'h02,
    parameter logic [7:0]  CODE_REFRESH  = 8'h01,
    parameter logic [7:0]  CODE_MRS      = 8'h10,
    parameter logic [7:0]  CODE_EMRS     = 8'h11,
    parameter logic [7:0]  CODE_EMRS2    = 8'h12,
    parameter logic [7:0]  CODE_EMRS3    = 8'h13,
    parameter logic [15:0] ARG_PRE_ALL   = 16'h0400,
    parameter logic [15:0] ARG_DLL_EN    = 16'h0002,
    parameter logic [15:0] ARG_DLL_RST   = 16'h0100,
    parameter logic [15:0] ARG_OCD_DFLT  = 16'h0380,
    parameter logic [15:0] ARG_OCD_EXIT  = 16'h0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [31:0] mode_word,
    input  logic [31:0] timing_val,
    input  logic [31:0] latency_val,
    input  logic [31:0] config_val,
    input  logic        wr_ready,
    output logic [2:0]  wr_sel,
    output logic [31:0] wr_data,
    output logic        wr_valid,
    output logic        done
);
    seq_state_e       state;
    logic [IDX_W-1:0] idx;
    logic             timer_load;
    logic             timer_expired;
    logic             handshake;
    wr_step_t         cur_step;

    assign handshake = (state == ST_WRITE) && wr_ready;

    // The timer is armed on every transition into the settling state.
    always_comb begin
        timer_load = 1'b0;
        if (state == ST_IDLE && start) begin
            timer_load = 1'b1;
        end else if (handshake && idx != STEP_LAST && settle_before(idx + 1'b1)) begin
            timer_load = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_SETTLE;
                        idx   <= STEP_PHY_CFG;
                    end
                end
                ST_SETTLE: begin
                    if (timer_expired) begin
                        state <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (wr_ready) begin
                        if (idx == STEP_LAST) begin
                            state <= ST_DONE;
                        end else begin
                            idx   <= idx + 1'b1;
                            state <= settle_before(idx + 1'b1) ? ST_SETTLE : ST_WRITE;
                        end
                    end
                end
                default: state <= ST_DONE;
            endcase
        end
    end

    settle_timer #(
        .SETTLE_CYCLES(SETTLE_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load   (timer_load),
        .expired(timer_expired)
    );

    init_step_rom #(
        .PHY_EN_BIT   (PHY_EN_BIT),
        .PHY_RST_BIT  (PHY_RST_BIT),
        .CAL_RST_BIT  (CAL_RST_BIT),
        .CAL_START_BIT(CAL_START_BIT),
        .CODE_DESELECT(CODE_DESELECT),
        .CODE_PRE     (CODE_PRE),
        .CODE_REFRESH (CODE_REFRESH),
        .CODE_MRS     (CODE_MRS),
        .CODE_EMRS    (CODE_EMRS),
        .CODE_EMRS2   (CODE_EMRS2),
        .CODE_EMRS3   (CODE_EMRS3),
        .ARG_PRE_ALL  (ARG_PRE_ALL),
        .ARG_DLL_EN   (ARG_DLL_EN),
        .ARG_DLL_RST  (ARG_DLL_RST),
        .ARG_OCD_DFLT (ARG_OCD_DFLT),
        .ARG_OCD_EXIT (ARG_OCD_EXIT)
    ) u_rom (
        .idx        (idx),
        .mode_word  (mode_word),
        .timing_val (timing_val),
        .latency_val(latency_val),
        .config_val (config_val),
        .step       (cur_step)
    );

    assign wr_valid = (state == ST_WRITE);
    assign wr_sel   = cur_step.sel;
    assign wr_data  = cur_step.data;
    assign done     = (state == ST_DONE);
endmodule

// File: rtl/ddr2_init_seq_chk.sv
module ddr2_init_seq_chk
    import ddr2_init_pkg::*;
#(
    parameter int SETTLE_CYCLES = 10000
) (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        wr_ready,
    input logic [2:0]  wr_sel,
    input logic [31:0] wr_data,
    input logic        wr_valid,
    input logic        done
);
    logic        seen_start;
    logic        after_cmd;
    logic [31:0] gap_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_start <= 1'b0;
            after_cmd  <= 1'b0;
            gap_cnt    <= '0;
        end else begin
            if (start) seen_start <= 1'b1;
            if (wr_valid && wr_ready) begin
                after_cmd <= (wr_sel == SEL_CMD);
                gap_cnt   <= '0;
            end else if (!wr_valid && gap_cnt != 32'hFFFF_FFFF) begin
                gap_cnt <= gap_cnt + 1'b1;
            end
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !seen_start |-> (!wr_valid && !done));

    assert_cmd_format_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_sel == SEL_CMD) |-> (wr_data[31:24] == 8'h00));

    assert_settle_gap_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && after_cmd) |-> (gap_cnt >= 32'(SETTLE_CYCLES)));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_sel) && $stable(wr_data)));

    assert_done_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    assert_done_after_config_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(wr_valid && wr_ready && wr_sel == SEL_CONFIG));

    assert_quiet_after_done_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> !wr_valid);
endmodule

bind ddr2_init_seq ddr2_init_seq_chk #(
    .SETTLE_CYCLES(SETTLE_CYCLES)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .wr_ready(wr_ready),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .wr_valid(wr_valid),
    .done    (done)
);

// File: tb/ddr2_init_seq_test.sv
module ddr2_init_seq_test;
    localparam int S = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] mode_word = '0;
    logic [31:0] timing_val = 32'h1111_2222;
    logic [31:0] latency_val = 32'h0000_0033;
    logic [31:0] config_val = 32'hC0DE_0044;
    logic        wr_ready = 1'b1;
    logic [2:0]  wr_sel;
    logic [31:0] wr_data;
    logic        wr_valid;
    logic        done;

    int tests = 0;
    int fails = 0;
    int stall_mode = 0;

    always #10 clk = ~clk;

    ddr2_init_seq #(.SETTLE_CYCLES(S)) uut (
        .clk(clk), .rst(rst), .start(start), .mode_word(mode_word),
        .timing_val(timing_val), .latency_val(latency_val), .config_val(config_val),
        .wr_ready(wr_ready), .wr_sel(wr_sel), .wr_data(wr_data),
        .wr_valid(wr_valid), .done(done)
    );

    // Monitor: records every handshake and when each write was first presented.
    int          cyc = 0;
    int          nw = 0;
    logic [2:0]  ms [0:31];
    logic [31:0] md [0:31];
    int          mfirst [0:31];
    int          mhs [0:31];
    bit          presented = 0;
    bit          start_seen = 0;
    int          start_cyc = 0;
    int          done_cyc = -1;
    int          hold_err = 0;
    logic        pv = 0, pr = 0;
    logic [2:0]  psel = '0;
    logic [31:0] pdata = '0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst) begin
            nw = 0; presented = 0; start_seen = 0; done_cyc = -1;
        end else begin
            if (start && !start_seen) begin start_seen = 1; start_cyc = cyc; end
            if (pv && !pr && !(wr_valid && wr_sel == psel && wr_data == pdata))
                hold_err = hold_err + 1;
            if (wr_valid && !presented && nw < 32) begin mfirst[nw] = cyc; presented = 1; end
            if (wr_valid && wr_ready && nw < 32) begin
                ms[nw] = wr_sel; md[nw] = wr_data; mhs[nw] = cyc;
                nw = nw + 1; presented = 0;
            end
            if (done && done_cyc < 0) done_cyc = cyc;
        end
        pv = wr_valid; pr = wr_ready; psel = wr_sel; pdata = wr_data;
    end

    // Ready driver: always ready, or a repeating stall pattern.
    initial begin
        int rc = 0;
        forever begin
            @(posedge clk); #1;
            rc = rc + 1;
            wr_ready = (stall_mode == 0) ? 1'b1 : ((rc % 5) >= 2);
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests = tests + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    // Expected program, written from the requirements.
    function automatic logic [2:0] exp_sel(input int i);
        if (i == 0) return 3'd0;
        if (i <= 2) return 3'd1;
        if (i <= 14) return 3'd2;
        return 3'(i - 12);
    endfunction

    function automatic logic [31:0] exp_data(input int i, input logic [31:0] m);
        case (i)
            0:  return 32'h0000_0001;
            1:  return 32'h0000_0003;
            2:  return 32'h0000_0004;
            3:  return {8'h00, 8'h0F, 16'h0000};
            4:  return {8'h00, 8'h02, 16'h0400};
            5:  return {8'h00, 8'h12, 16'h0000};
            6:  return {8'h00, 8'h13, 16'h0000};
            7:  return {8'h00, 8'h11, 16'h0002};
            8:  return {8'h00, 8'h10, 16'h0100};
            9:  return {8'h00, 8'h02, 16'h0400};
            10: return {8'h00, 8'h01, 16'h0000};
            11: return {8'h00, 8'h01, 16'h0000};
            12: return {8'h00, 8'h10, m[15:0]};
            13: return {8'h00, 8'h11, 16'h0382};
            14: return {8'h00, 8'h11, 16'h0002 | m[31:16]};
            15: return timing_val;
            16: return latency_val;
            default: return config_val;
        endcase
    endfunction

    function automatic string req_of(input int i);
        if (i == 0) return "R2";
        if (i <= 2) return "R3";
        if (i == 12 || i == 14) return "R5";
        if (i <= 14) return "R4";
        return "R7";
    endfunction

    function automatic int exp_gap(input int i);
        if (i == 0 || i == 1 || (i >= 3 && i <= 15)) return S + 1;
        return 1;
    endfunction

    task automatic do_reset();
        @(posedge clk); #1; rst = 1'b1; start = 1'b0;
        repeat (3) @(posedge clk);
        #1; rst = 1'b0;
    endtask

    task automatic pulse_start();
        @(posedge clk); #1; start = 1'b1;
        @(posedge clk); #1; start = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done && n < 5000) begin @(posedge clk); n = n + 1; end
        check(done == 1'b1, tag, "done reached", 32'(done), 32'd1);
    endtask

    task automatic check_program(input logic [31:0] m, input string tag);
        check(nw == 18, "R4", {tag, " write count"}, 32'(nw), 32'd18);
        for (int i = 0; i < 18 && i < nw; i++) begin
            int gap;
            check(ms[i] == exp_sel(i) && md[i] == exp_data(i, m), req_of(i),
                  $sformatf("%s step %0d data(sel %0d)", tag, i, ms[i]), md[i], exp_data(i, m));
            gap = (i == 0) ? mfirst[0] - start_cyc : mfirst[i] - mhs[i-1];
            check(gap == exp_gap(i), (i >= 3 && i <= 15) ? "R6" : req_of(i),
                  $sformatf("%s step %0d gap", tag, i), 32'(gap), 32'(exp_gap(i)));
        end
        if (nw == 18)
            check(done_cyc - mhs[17] == 1, "R9", {tag, " done latency"},
                  32'(done_cyc - mhs[17]), 32'd1);
        check(hold_err == 0, "R8", {tag, " hold under stall"}, 32'(hold_err), 32'd0);
    endtask

    task automatic test_reset_idle();
        do_reset();
        repeat (S + 10) @(negedge clk);
        check(wr_valid == 1'b0 && done == 1'b0 && nw == 0, "R1", "idle after reset",
              {30'd0, wr_valid, done}, 32'd0);
    endtask

    task automatic test_plain_run();
        stall_mode = 0; mode_word = 32'h5A40_0642;
        do_reset(); pulse_start(); wait_done("R9");
        @(negedge clk);
        check_program(mode_word, "plain");
        repeat (10) @(negedge clk);
        check(done == 1'b1, "R9", "done sticky", 32'(done), 32'd1);
        pulse_start();
        repeat (S + 10) @(negedge clk);
        check(nw == 18 && done == 1'b1 && !wr_valid, "R10", "start after done ignored",
              32'(nw), 32'd18);
    endtask

    task automatic test_stall_and_restart();
        stall_mode = 1; mode_word = 32'h1234_8765; hold_err = 0;
        timing_val = 32'hAAAA_0001; latency_val = 32'h0000_0007; config_val = 32'h8000_00F0;
        do_reset(); pulse_start();
        while (nw < 5) @(posedge clk);
        repeat (3) @(posedge clk);
        pulse_start();
        wait_done("R10");
        @(negedge clk);
        check_program(mode_word, "stall");
        stall_mode = 0;
    endtask

    task automatic test_midrun_reset();
        stall_mode = 0;
        do_reset(); pulse_start();
        while (nw < 4) @(posedge clk);
        #1; rst = 1'b1;
        @(negedge clk);
        check(!wr_valid && !done, "R1", "outputs low in reset", 32'(wr_valid), 32'd0);
        repeat (2) @(posedge clk);
        #1; rst = 1'b0;
        repeat (S + 10) @(negedge clk);
        check(!wr_valid && !done && nw == 0, "R1", "idle after mid-run reset", 32'(nw), 32'd0);
    endtask

    initial begin
        test_reset_idle();
        test_plain_run();
        test_stall_and_restart();
        test_midrun_reset();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(20 * 100000);
        tests = tests + 1;
        fails = fails + 1;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule